// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows the power state of a processor core, one step per bus clock. It watches the active-low stop-clock, sleep, deep-sleep and core-reset requests, each through a two-flop synchroniser. It also takes synchronous pulses: a halt instruction, snoop start, snoop done, and five interrupt event types. The five types are SMI, INIT, LINT0, LINT1 and a bus interrupt message. From these inputs it derives the current state and a set of indications for the rest of the chip.

Entry into the stop-grant state goes through an acknowledge phase of fixed length. Leaving deep sleep goes through a PLL settle interval, given as a cycle count. Interrupt events that arrive while the clock is stopped are held, one bit per type. They are handed back to the core as a one-cycle pulse once it runs again. Sequences that break the protocol set a sticky violation flag. Only a core reset clears that flag.

Top module: `cpu_pwr_state_ctrl`

## Requirements
- R1: After `rst_n` is released, `state_o` is 0 (normal), and `grant_ack_o`, `break_pend_o`, `pwr_low_o`, `illegal_o` and `evt_o` are all 0. State codes are: 0 normal, 1 auto-halt, 2 stop-grant, 3 snoop, 4 sleep, 5 deep sleep, 6 acknowledge wait, 7 PLL settle.
- R2: A `halt_i` pulse in normal gives auto-halt on the next cycle. In auto-halt, any event pulse returns the machine to normal; the event bits are 0 SMI, 1 INIT, 2 LINT0, 3 LINT1 and 4 bus message. LINT0 wakes the machine only while `int_en_i` is 1.
- R3: When stop-clock is asserted in normal or auto-halt, `grant_ack_o` is high for one cycle, and the state is 6 from that cycle on. The state becomes stop-grant exactly GRANT_DLY (default 20) cycles after the acknowledge cycle.
- R4: When stop-clock is released in stop-grant, the machine returns to the state it left, either normal or auto-halt.
- R5: A `snoop_start_i` pulse in stop-grant or auto-halt moves the machine to the snoop state. A `snoop_done_i` pulse returns it to the state it came from.
- R6: The machine enters sleep only from stop-grant, when the sleep request is asserted. A sleep request in normal, auto-halt, snoop or acknowledge wait sets `illegal_o` and causes no state change.
- R7: Events that arrive in stop-grant are held, at most once per type. `evt_o` is 0 while they are held. On the first cycle back in normal, `evt_o` carries the held bits for exactly one cycle.
- R8: `break_pend_o` is 1 in stop-grant whenever any event is held, and `int_en_i` has no effect on it.
- R9: When the deep-sleep request is asserted in sleep, the machine enters deep sleep. When the request is released, state 7 is held for PLL_CYC cycles, and then the state is sleep.
- R10: `pwr_low_o` is 1 exactly while the state is deep sleep. It goes to 0 when the deep-sleep request is released.
- R11: In sleep, deep sleep and PLL settle, events are not held. A snoop start in these states sets `illegal_o`.
- R12: After sleep hands back to stop-grant, releasing stop-clock fewer than MIN_GAP (default 10) clocks after the sleep release sets `illegal_o`. A gap of MIN_GAP or more does not set it.
- R13: A core reset in stop-grant leaves the state at stop-grant and clears held events and `illegal_o`. A core reset in any other state, sleep included, returns the machine straight to normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| stop_clk_n | input | 1 | Stop-clock request, active low |
| sleep_n | input | 1 | Sleep request, active low |
| deep_sleep_n | input | 1 | Deep-sleep request, active low |
| core_reset_n | input | 1 | Core reset request, active low |
| halt_i | input | 1 | Halt instruction pulse |
| snoop_start_i | input | 1 | Snoop transaction start pulse |
| snoop_done_i | input | 1 | Snoop serviced pulse |
| evt_i | input | 5 | Event pulses: SMI, INIT, LINT0, LINT1, bus message |
| int_en_i | input | 1 | Maskable interrupt enable |
| state_o | output | 3 | Current state code |
| grant_ack_o | output | 1 | Stop-grant acknowledge pulse |
| break_pend_o | output | 1 | Break event pending in stop-grant |
| pwr_low_o | output | 1 | Power-status indicator, high in deep sleep |
| illegal_o | output | 1 | Sticky sequence violation flag |
| evt_o | output | 5 | Held events, presented on return to normal |

## Verification
The acknowledge-to-grant and settle intervals are counted cycle by cycle from their first cycle. This separates an off-by-one delay from a correct one. Stop-grant is entered once from normal and once from auto-halt, which shows whether the return state is remembered. The sleep release gap is driven at 12 and at 5 clocks, which splits legal timing from a violation. Duplicate SMI pulses and a masked LINT0 show single capture and that the pending indication does not depend on the enable. A core reset is applied in stop-grant and in sleep, which shows the two different reset outcomes.

// File: rtl/pls_pkg.sv
`timescale 1ns/1ps
package pls_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL   = 3'd0,
    ST_AUTOHALT = 3'd1,
    ST_GRANT    = 3'd2,
    ST_SNOOP    = 3'd3,
    ST_SLEEP    = 3'd4,
    ST_DEEP     = 3'd5,
    ST_ACKWAIT  = 3'd6,
    ST_WAKING   = 3'd7
  } pstate_e;

  localparam int EVT_W    = 5;
  localparam int EV_SMI   = 0;
  localparam int EV_INIT  = 1;
  localparam int EV_LINT0 = 2;
  localparam int EV_LINT1 = 3;
  localparam int EV_MSG   = 4;

  // Wake from auto-halt: any new or held event, LINT0 gated by the enable.
  function automatic logic halt_break(logic [EVT_W-1:0] ev,
                                      logic [EVT_W-1:0] held,
                                      logic ie);
    logic [EVT_W-1:0] m;
    m = ev | held;
    m[EV_LINT0] = m[EV_LINT0] & ie;
    return |m;
  endfunction

  // Counter cnt is 0 on the first cycle of a span of len cycles.
  function automatic logic span_done(logic [31:0] cnt, int unsigned len);
    return cnt == 32'(len - 1);
  endfunction

  // Gap counter reads g-1 when g clocks separate the two releases.
  function automatic logic gap_short(logic [31:0] cnt, int unsigned min_gap);
    return (cnt + 32'd1) < 32'(min_gap);
  endfunction

endpackage

// File: rtl/pls_sync.sv
`timescale 1ns/1ps
module pls_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_n,
  output logic [W-1:0] q_n
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= 2'b11;
      else        st <= {st[0], d_n[i]};
    end
    assign q_n[i] = st[1];
  end
endmodule

// File: rtl/pls_cnt.sv
`timescale 1ns/1ps
module pls_cnt #(
  parameter int W    = 8,
  parameter int MAXV = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] LIM = W'(MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  q_o <= '0;
    else if (clr_i)              q_o <= '0;
    else if (en_i && q_o != LIM) q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/pls_evt_latch.sv
`timescale 1ns/1ps
module pls_evt_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_i,
  input  logic         clr_i,
  input  logic [W-1:0] ev_i,
  output logic [W-1:0] held_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held_o <= '0;
    else if (clr_i) held_o <= '0;
    else if (cap_i) held_o <= held_o | ev_i;
  end

  // R7/R11: no new bit appears unless capture was open
  a_r7_capture_only: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> ($countones(held_o) <= $countones($past(held_o))));
endmodule

// File: rtl/cpu_pwr_state_ctrl.sv
`timescale 1ns/1ps
module cpu_pwr_state_ctrl
  import pls_pkg::*;
#(
  parameter int GRANT_DLY = 20,
  parameter int PLL_CYC   = 3000,
  parameter int MIN_GAP   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_clk_n,
  input  logic             sleep_n,
  input  logic             deep_sleep_n,
  input  logic             core_reset_n,
  input  logic             halt_i,
  input  logic             snoop_start_i,
  input  logic             snoop_done_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             int_en_i,
  output logic [2:0]       state_o,
  output logic             grant_ack_o,
  output logic             break_pend_o,
  output logic             pwr_low_o,
  output logic             illegal_o,
  output logic [EVT_W-1:0] evt_o
);
  localparam int CNT_MAX = (GRANT_DLY > PLL_CYC) ? GRANT_DLY : PLL_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int GAP_W   = $clog2(MIN_GAP + 1);

  // synchronised requests, asserted-high views
  logic [3:0] req_raw_n, req_syn_n;
  logic stp_req, slp_req, dps_req, crst;
  assign req_raw_n = {core_reset_n, deep_sleep_n, sleep_n, stop_clk_n};

  pls_sync #(.W(4)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_n(req_raw_n), .q_n(req_syn_n)
  );
  assign stp_req = ~req_syn_n[0];
  assign slp_req = ~req_syn_n[1];
  assign dps_req = ~req_syn_n[2];
  assign crst    = ~req_syn_n[3];

  pstate_e state_q, nxt, origin_q, ret_q;
  logic [CNT_W-1:0] cnt_q;
  logic [GAP_W-1:0] gap_q;
  logic [EVT_W-1:0] held;
  logic gap_arm_q, gap_arm_d, illegal_q;

  // named internal events
  logic st_change, ev_capture, ev_clear, sleep_to_grant;
  logic sleep_misuse, snoop_misuse, gap_viol, in_low, slp_ok_state;

  assign st_change      = (nxt != state_q);
  assign ev_capture     = (state_q == ST_GRANT) ||
                          (state_q == ST_SNOOP && ret_q == ST_GRANT);
  assign ev_clear       = crst || (state_q == ST_NORMAL);
  assign sleep_to_grant = (state_q == ST_SLEEP) && (nxt == ST_GRANT);
  assign in_low         = (state_q == ST_SLEEP) || (state_q == ST_DEEP) ||
                          (state_q == ST_WAKING);
  assign slp_ok_state   = in_low || (state_q == ST_GRANT);
  assign sleep_misuse   = slp_req && !crst && !slp_ok_state;
  assign snoop_misuse   = snoop_start_i && !crst && in_low;
  assign gap_viol       = (state_q == ST_GRANT) && gap_arm_q && !stp_req &&
                          !crst && gap_short(32'(gap_q), MIN_GAP);

  pls_cnt #(.W(CNT_W), .MAXV(CNT_MAX)) i_span_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(st_change), .en_i(1'b1), .q_o(cnt_q)
  );

  pls_cnt #(.W(GAP_W), .MAXV(MIN_GAP)) i_gap_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(sleep_to_grant), .en_i(gap_arm_q),
    .q_o(gap_q)
  );

  pls_evt_latch #(.W(EVT_W)) i_evt (
    .clk(clk), .rst_n(rst_n), .cap_i(ev_capture), .clr_i(ev_clear),
    .ev_i(evt_i), .held_o(held)
  );

  // next state
  always_comb begin
    nxt = state_q;
    if (crst) begin
      nxt = (state_q == ST_GRANT) ? ST_GRANT : ST_NORMAL;
    end else begin
      unique case (state_q)
        ST_NORMAL: begin
          if (stp_req)     nxt = ST_ACKWAIT;
          else if (halt_i) nxt = ST_AUTOHALT;
        end
        ST_AUTOHALT: begin
          if (stp_req)                              nxt = ST_ACKWAIT;
          else if (halt_break(evt_i, held, int_en_i)) nxt = ST_NORMAL;
          else if (snoop_start_i)                   nxt = ST_SNOOP;
        end
        ST_ACKWAIT: begin
          if (!stp_req)                               nxt = origin_q;
          else if (span_done(32'(cnt_q), GRANT_DLY))  nxt = ST_GRANT;
        end
        ST_GRANT: begin
          if (slp_req)            nxt = ST_SLEEP;
          else if (!stp_req)      nxt = origin_q;
          else if (snoop_start_i) nxt = ST_SNOOP;
        end
        ST_SNOOP: begin
          if (snoop_done_i) nxt = ret_q;
        end
        ST_SLEEP: begin
          if (dps_req)       nxt = ST_DEEP;
          else if (!slp_req) nxt = ST_GRANT;
        end
        ST_DEEP: begin
          if (!dps_req) nxt = ST_WAKING;
        end
        ST_WAKING: begin
          if (span_done(32'(cnt_q), PLL_CYC)) nxt = ST_SLEEP;
        end
        default: nxt = ST_NORMAL;
      endcase
    end
  end

  assign gap_arm_d = ((nxt == ST_GRANT) || (nxt == ST_SNOOP)) &&
                     (gap_arm_q || state_q == ST_SLEEP) && !crst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_NORMAL;
      origin_q  <= ST_NORMAL;
      ret_q     <= ST_NORMAL;
      gap_arm_q <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= nxt;
      gap_arm_q <= gap_arm_d;
      if (nxt == ST_ACKWAIT && state_q != ST_ACKWAIT)
        origin_q <= state_q;
      if (nxt == ST_SNOOP && state_q != ST_SNOOP)
        ret_q <= state_q;
      if (crst)
        illegal_q <= 1'b0;
      else if (sleep_misuse || snoop_misuse || gap_viol)
        illegal_q <= 1'b1;
    end
  end

  assign state_o      = state_q;
  assign grant_ack_o  = (state_q == ST_ACKWAIT) && (cnt_q == '0);
  assign break_pend_o = (state_q == ST_GRANT) && (|held);
  assign pwr_low_o    = (state_q == ST_DEEP);
  assign illegal_o    = illegal_q;
  assign evt_o        = (state_q == ST_NORMAL) ? held : '0;

  // R3: acknowledge lasts one cycle
  a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    grant_ack_o |=> !grant_ack_o);
  // R3: grant reached only after the full acknowledge span
  a_r3_grant_span: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GRANT && $past(state_q) == ST_ACKWAIT)
      |-> (32'($past(cnt_q)) == 32'(GRANT_DLY - 1)));
  // R6: sleep is entered from stop-grant (or re-entered after settle)
  a_r6_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && $past(state_q) != ST_SLEEP)
      |-> ($past(state_q) == ST_GRANT || $past(state_q) == ST_WAKING));
  // R9: settle never outlasts its span
  a_r9_settle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKING) |-> (32'(cnt_q) < 32'(PLL_CYC)));
  // R10: indicator rises only out of sleep
  a_r10_psi_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_low_o) |-> ($past(state_q) == ST_SLEEP));
  // R12: violation flag holds until a core reset
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_o && !crst) |=> illegal_o);
endmodule

// File: tb/test_cpu_pwr_state_ctrl.sv
`timescale 1ns/1ps
module test_cpu_pwr_state_ctrl;
  localparam int GRANT_DLY = 20;
  localparam int PLL_CYC   = 3000;
  localparam int MIN_GAP   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_clk_n = 1'b1, sleep_n = 1'b1, deep_sleep_n = 1'b1;
  logic core_reset_n = 1'b1;
  logic halt_i = 1'b0, snoop_start_i = 1'b0, snoop_done_i = 1'b0;
  logic [4:0] evt_i = '0;
  logic int_en_i = 1'b1;
  logic [2:0] state_o;
  logic grant_ack_o, break_pend_o, pwr_low_o, illegal_o;
  logic [4:0] evt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cpu_pwr_state_ctrl #(.GRANT_DLY(GRANT_DLY), .PLL_CYC(PLL_CYC),
                       .MIN_GAP(MIN_GAP)) i_cpu_pwr_state_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_clk_n(stop_clk_n), .sleep_n(sleep_n),
    .deep_sleep_n(deep_sleep_n), .core_reset_n(core_reset_n),
    .halt_i(halt_i), .snoop_start_i(snoop_start_i),
    .snoop_done_i(snoop_done_i), .evt_i(evt_i), .int_en_i(int_en_i),
    .state_o(state_o), .grant_ack_o(grant_ack_o),
    .break_pend_o(break_pend_o), .pwr_low_o(pwr_low_o),
    .illegal_o(illegal_o), .evt_o(evt_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_halt();
    step(1); halt_i = 1'b1; step(1); halt_i = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_evt(logic [4:0] v);
    step(1); evt_i = v; step(1); evt_i = '0; @(negedge clk);
  endtask

  task automatic pulse_snoop(bit start);
    step(1);
    if (start) snoop_start_i = 1'b1; else snoop_done_i = 1'b1;
    step(1);
    snoop_start_i = 1'b0; snoop_done_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_state(int exp, int max, string req);
    bit hit = 0;
    for (int i = 0; i < max && !hit; i++) begin
      @(negedge clk);
      if (state_o == 3'(exp)) hit = 1;
    end
    chk(req, "state reached", int'(state_o), exp);
  endtask

  task automatic core_reset_pulse();
    step(1); core_reset_n = 1'b0; step(4); core_reset_n = 1'b1; step(4);
  endtask

  // R3: ack for one cycle, grant exactly GRANT_DLY cycles later
  task automatic enter_grant();
    bit seen = 0;
    step(1); stop_clk_n = 1'b0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (grant_ack_o) seen = 1;
    end
    chk("R3", "ack seen", int'(seen), 1);
    chk("R3", "ack state", int'(state_o), 6);
    for (int k = 1; k <= GRANT_DLY; k++) begin
      @(negedge clk);
      if (k == 1) chk("R3", "ack width", int'(grant_ack_o), 0);
      if (k == GRANT_DLY - 1) chk("R3", "still waiting", int'(state_o), 6);
      if (k == GRANT_DLY) chk("R3", "grant entered", int'(state_o), 2);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "state", int'(state_o), 0);
    chk("R1", "ack", int'(grant_ack_o), 0);
    chk("R1", "pbe", int'(break_pend_o), 0);
    chk("R1", "psi", int'(pwr_low_o), 0);
    chk("R1", "illegal", int'(illegal_o), 0);
    chk("R1", "evt", int'(evt_o), 0);
  endtask

  task automatic t_halt();
    pulse_halt();
    chk("R2", "halt entry", int'(state_o), 1);
    int_en_i = 1'b0;
    pulse_evt(5'b00100);
    chk("R2", "masked LINT0 keeps halt", int'(state_o), 1);
    int_en_i = 1'b1;
    pulse_evt(5'b01000);
    chk("R2", "LINT1 wakes", int'(state_o), 0);
  endtask

  task automatic t_grant_normal();
    enter_grant();
    step(1); stop_clk_n = 1'b1;
    wait_state(0, 10, "R4");
  endtask

  task automatic t_grant_halt();
    pulse_halt();
    enter_grant();
    step(1); stop_clk_n = 1'b1;
    wait_state(1, 10, "R4");
    pulse_evt(5'b00001);
    chk("R2", "SMI wakes", int'(state_o), 0);
  endtask

  task automatic t_snoop();
    enter_grant();
    pulse_snoop(1);
    chk("R5", "snoop entry", int'(state_o), 3);
    step(3); @(negedge clk);
    chk("R5", "snoop held", int'(state_o), 3);
    pulse_snoop(0);
    chk("R5", "snoop return", int'(state_o), 2);
    step(1); stop_clk_n = 1'b1;
    wait_state(0, 10, "R4");
  endtask

  task automatic t_events();
    int_en_i = 1'b0;
    enter_grant();
    pulse_evt(5'b00001);
    pulse_evt(5'b00001);
    pulse_evt(5'b00100);
    chk("R8", "pbe with masked enable", int'(break_pend_o), 1);
    chk("R7", "evt quiet while held", int'(evt_o), 0);
    step(1); stop_clk_n = 1'b1;
    wait_state(0, 10, "R7");
    chk("R7", "evt presented", int'(evt_o), 5);
    @(negedge clk);
    chk("R7", "evt one cycle", int'(evt_o), 0);
    int_en_i = 1'b1;
  endtask

  task automatic t_sleep_misuse();
    step(1); sleep_n = 1'b0;
    step(5); @(negedge clk);
    chk("R6", "flag on sleep in normal", int'(illegal_o), 1);
    chk("R6", "no sleep from normal", int'(state_o), 0);
    step(1); sleep_n = 1'b1;
    step(4);
    core_reset_pulse();
    @(negedge clk);
    chk("R13", "flag cleared", int'(illegal_o), 0);
  endtask

  task automatic t_deep_and_gap_ok();
    enter_grant();
    step(1); sleep_n = 1'b0;
    wait_state(4, 10, "R6");
    chk("R6", "legal sleep no flag", int'(illegal_o), 0);
    step(1); deep_sleep_n = 1'b0;
    wait_state(5, 10, "R9");
    chk("R10", "psi in deep", int'(pwr_low_o), 1);
    pulse_evt(5'b00010);
    step(1); deep_sleep_n = 1'b1;
    wait_state(7, 10, "R9");
    chk("R10", "psi off on exit", int'(pwr_low_o), 0);
    for (int k = 1; k <= PLL_CYC; k++) begin
      @(negedge clk);
      if (k == PLL_CYC - 1) chk("R9", "still settling", int'(state_o), 7);
      if (k == PLL_CYC) chk("R9", "back in sleep", int'(state_o), 4);
    end
    step(1); sleep_n = 1'b1;
    step(12); stop_clk_n = 1'b1;
    wait_state(0, 20, "R12");
    chk("R11", "deep event not held", int'(evt_o), 0);
    chk("R12", "gap 12 no flag", int'(illegal_o), 0);
  endtask

  task automatic t_gap_bad();
    enter_grant();
    step(1); sleep_n = 1'b0;
    wait_state(4, 10, "R6");
    step(1); sleep_n = 1'b1;
    step(5); stop_clk_n = 1'b1;
    wait_state(0, 20, "R12");
    chk("R12", "gap 5 flagged", int'(illegal_o), 1);
    core_reset_pulse();
  endtask

  task automatic t_sleep_snoop_reset();
    enter_grant();
    step(1); sleep_n = 1'b0;
    wait_state(4, 10, "R11");
    pulse_snoop(1);
    chk("R11", "snoop in sleep flagged", int'(illegal_o), 1);
    chk("R11", "snoop in sleep ignored", int'(state_o), 4);
    step(1); core_reset_n = 1'b0; sleep_n = 1'b1; stop_clk_n = 1'b1;
    wait_state(0, 10, "R13");
    step(2); core_reset_n = 1'b1;
    step(4); @(negedge clk);
    chk("R13", "normal after sleep reset", int'(state_o), 0);
    chk("R13", "flag cleared by reset", int'(illegal_o), 0);
  endtask

  task automatic t_grant_reset();
    enter_grant();
    pulse_evt(5'b00010);
    chk("R8", "INIT pending", int'(break_pend_o), 1);
    step(1); core_reset_n = 1'b0;
    step(4); @(negedge clk);
    chk("R13", "stays in grant", int'(state_o), 2);
    chk("R13", "held cleared", int'(break_pend_o), 0);
    step(1); core_reset_n = 1'b1;
    step(3); @(negedge clk);
    chk("R13", "grant after release", int'(state_o), 2);
    step(1); stop_clk_n = 1'b1;
    wait_state(0, 10, "R13");
    chk("R13", "no stale events", int'(evt_o), 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_halt();
    t_grant_normal();
    t_grant_halt();
    t_snoop();
    t_events();
    t_sleep_misuse();
    t_deep_and_gap_ok();
    t_gap_bad();
    t_sleep_snoop_reset();
    t_grant_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule